// File: doc/BRIEF.md
# Storage Key Reference and Change Recorder

This block runs once after each address translation has succeeded. It takes the absolute address of the access, the access kind (data fetch, data store or instruction fetch), the permissions the translation produced and the installed memory size. For an address inside installed memory it reads the 8-bit storage key of the 4 KiB frame from an external key RAM, sets the referenced flag, sets the changed flag as well on a store, and writes the key back. It then returns the permissions to be cached together with a one-cycle done pulse.

The permissions it returns are those it received, with one exception. A data fetch or an instruction fetch that finds the frame's changed flag still clear loses write permission. The cached entry is then read-only, so the first later store to that frame misses, translates again and passes through this block a second time, which records the change. Addresses at or beyond the memory size bypass all key handling.

Top module: `skey_rc_updater`

## Requirements
- R1: When `req_addr` is greater than or equal to `mem_size`, the accepted request makes no key read or key write. `done` pulses on the next cycle and `perm_out` equals `req_perm`.
- R2: The key RAM index used for both the read and the write-back is `req_addr >> 12`, i.e. the address divided by 4096.
- R3: Every in-range access writes back the key with bit 2 (value 0x04, referenced) set, for all three access kinds.
- R4: For `req_kind` = 1 (store) the written key has bit 1 (value 0x02, changed) set. For `req_kind` = 0 (fetch) and 2 (instruction fetch), bit 1 is written back as it was read.
- R5: Key bits other than bits 2 and 1 are written back unchanged.
- R6: For fetch and instruction fetch, when bit 1 of the key that was read is 0, `perm_out` equals `req_perm` with bit 1 (write) cleared. When bit 1 of the key is 1, `perm_out` equals `req_perm`. Permission bits are: bit 0 read, bit 1 write, bit 2 execute.
- R7: For a store, `perm_out` equals `req_perm` whatever the key holds.
- R8: An in-range request accepted at clock edge N drives `key_rd_en` in the cycle after edge N. It drives `key_wr_en` two cycles after that. `done` is high for the single cycle after the write cycle. Each access makes exactly one key read and one key write.
- R9: `busy` is high from the key read cycle through the write-back cycle. A `req_valid` presented while `busy` is high is ignored and produces no key access and no `done`.
- R10: After reset, `busy`, `done`, `key_rd_en` and `key_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | 20 | Absolute byte address of the access |
| req_kind | input | 2 | 0 fetch, 1 store, 2 instruction fetch |
| req_perm | input | 3 | Incoming permissions: bit 0 read, bit 1 write, bit 2 execute |
| mem_size | input | 21 | Installed memory size in bytes |
| busy | output | 1 | Key read-modify-write in progress |
| done | output | 1 | One-cycle completion pulse |
| perm_out | output | 3 | Adjusted permissions, valid while `done` is high |
| key_rd_en | output | 1 | Key RAM read strobe |
| key_rd_idx | output | 8 | Key RAM read index |
| key_rd_data | input | 8 | Key RAM read data, valid one cycle after `key_rd_en` |
| key_wr_en | output | 1 | Key RAM write strobe |
| key_wr_idx | output | 8 | Key RAM write index |
| key_wr_data | output | 8 | Updated key |

## Verification
Accesses of all three kinds are driven against keys whose changed flag is clear and against keys whose changed flag is set. This separates write-permission withdrawal on reads from pass-through on stores and from pass-through on reads of frames that are already dirty. Keys carrying random upper bits show whether the update disturbs bits it should not touch. Addresses one byte below and exactly at the memory size separate the bypass path from the key path, and the measured latency confirms which path was taken. A request pulsed in the middle of a busy sequence must leave the key-access counts and the done count unchanged.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_IFETCH = 2'd2,
    ACC_RSVD   = 2'd3
  } acc_kind_e;

  localparam int KEY_REF_BIT = 2;
  localparam int KEY_CHG_BIT = 1;

  localparam int PERM_RD_BIT = 0;
  localparam int PERM_WR_BIT = 1;
  localparam int PERM_EX_BIT = 2;
  localparam int PERM_W      = 3;
endpackage

// File: rtl/skey_range.sv
module skey_range #(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   mem_size,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    in_range = ({1'b0, addr} < mem_size);
    idx      = addr[ADDR_W-1:PAGE_SHIFT];
  end
endmodule

// File: rtl/skey_modify.sv
module skey_modify
  import skey_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic [KEY_W-1:0]  old_key,
  input  acc_kind_e         kind,
  input  logic [PERM_W-1:0] perm_in,
  output logic [KEY_W-1:0]  new_key,
  output logic [PERM_W-1:0] perm_res
);
  logic is_store;

  always_comb begin
    is_store = (kind == ACC_STORE);
    new_key  = old_key;
    new_key[KEY_REF_BIT] = 1'b1;
    if (is_store) begin
      new_key[KEY_CHG_BIT] = 1'b1;
    end
    perm_res = perm_in;
    if (!is_store && !old_key[KEY_CHG_BIT]) begin
      perm_res[PERM_WR_BIT] = 1'b0;
    end
  end
endmodule

// File: rtl/skey_seq.sv
module skey_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_range,
  output logic accept,
  output logic rd_en,
  output logic cap_en,
  output logic wr_en,
  output logic busy,
  output logic done
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WB} seq_state_e;

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    accept  = start && (state_q == S_IDLE);
    rd_en   = (state_q == S_RD);
    cap_en  = (state_q == S_WAIT);
    wr_en   = (state_q == S_WB);
    busy    = (state_q != S_IDLE);
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept && in_range) state_d = S_RD;
      S_RD:    state_d = S_WAIT;
      S_WAIT:  state_d = S_WB;
      S_WB:    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    done_d = wr_en || (accept && !in_range);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // R8
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en, 2));
  // R8
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_en));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(start));
endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int KEY_W      = 8,
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [PERM_W-1:0] req_perm,
  input  logic [ADDR_W:0]   mem_size,
  output logic              busy,
  output logic              done,
  output logic [PERM_W-1:0] perm_out,
  output logic              key_rd_en,
  output logic [IDX_W-1:0]  key_rd_idx,
  input  logic [KEY_W-1:0]  key_rd_data,
  output logic              key_wr_en,
  output logic [IDX_W-1:0]  key_wr_idx,
  output logic [KEY_W-1:0]  key_wr_data
);
  logic              in_range, accept, cap_en;
  logic [IDX_W-1:0]  req_idx;
  logic [IDX_W-1:0]  idx_q, idx_d;
  acc_kind_e         kind_q, kind_d;
  logic [PERM_W-1:0] perm_in_q, perm_in_d;
  logic [PERM_W-1:0] perm_res_q, perm_res_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [KEY_W-1:0]  mod_key;
  logic [PERM_W-1:0] mod_perm;

  skey_range #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_range (
    .addr     (req_addr),
    .mem_size (mem_size),
    .in_range (in_range),
    .idx      (req_idx)
  );

  skey_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (req_valid),
    .in_range (in_range),
    .accept   (accept),
    .rd_en    (key_rd_en),
    .cap_en   (cap_en),
    .wr_en    (key_wr_en),
    .busy     (busy),
    .done     (done)
  );

  skey_modify #(.KEY_W(KEY_W)) u_modify (
    .old_key  (key_rd_data),
    .kind     (kind_q),
    .perm_in  (perm_in_q),
    .new_key  (mod_key),
    .perm_res (mod_perm)
  );

  always_comb begin
    idx_d      = idx_q;
    kind_d     = kind_q;
    perm_in_d  = perm_in_q;
    perm_res_d = perm_res_q;
    key_d      = key_q;
    if (accept) begin
      idx_d     = req_idx;
      kind_d    = acc_kind_e'(req_kind);
      perm_in_d = req_perm;
      if (!in_range) begin
        perm_res_d = req_perm;
      end
    end
    if (cap_en) begin
      key_d      = mod_key;
      perm_res_d = mod_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      kind_q     <= ACC_FETCH;
      perm_in_q  <= '0;
      perm_res_q <= '0;
      key_q      <= '0;
    end else begin
      idx_q      <= idx_d;
      kind_q     <= kind_d;
      perm_in_q  <= perm_in_d;
      perm_res_q <= perm_res_d;
      key_q      <= key_d;
    end
  end

  assign key_rd_idx  = idx_q;
  assign key_wr_idx  = idx_q;
  assign key_wr_data = key_q;
  assign perm_out    = perm_res_q;

  // R1
  skip_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (!key_rd_en && done));
  // R2
  wr_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |-> (key_wr_idx == $past(key_rd_idx, 2)));
  // R3
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |-> key_wr_data[KEY_REF_BIT]);
  // R5
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |-> ((key_wr_data & ~KEY_W'(6)) == ($past(key_rd_data) & ~KEY_W'(6))));
  // R6
  perm_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(key_wr_en) |-> ((perm_out & ~perm_in_q) == '0));
endmodule

// File: tb/tb_skey_rc_updater.sv
module tb_skey_rc_updater;
  localparam int ADDR_W = 20;
  localparam int IDX_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_kind;
  logic [2:0]        req_perm;
  logic [ADDR_W:0]   mem_size;
  logic              busy, done;
  logic [2:0]        perm_out;
  logic              key_rd_en, key_wr_en;
  logic [IDX_W-1:0]  key_rd_idx, key_wr_idx;
  logic [7:0]        key_rd_data, key_wr_data;

  logic              ld_en;
  logic [IDX_W-1:0]  ld_idx;
  logic [7:0]        ld_data;
  logic [7:0]        kmem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [IDX_W-1:0] last_rd_idx, last_wr_idx;
  logic [7:0]       last_wr_data;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  skey_rc_updater dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_perm(req_perm), .mem_size(mem_size),
    .busy(busy), .done(done), .perm_out(perm_out),
    .key_rd_en(key_rd_en), .key_rd_idx(key_rd_idx), .key_rd_data(key_rd_data),
    .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data)
  );

  always @(posedge clk) begin
    if (ld_en) kmem[ld_idx] <= ld_data;
    else if (key_wr_en) kmem[key_wr_idx] <= key_wr_data;
    if (key_rd_en) key_rd_data <= kmem[key_rd_idx];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (key_rd_en) begin rd_cnt <= rd_cnt + 1; last_rd_idx <= key_rd_idx; end
      if (key_wr_en) begin wr_cnt <= wr_cnt + 1; last_wr_idx <= key_wr_idx; last_wr_data <= key_wr_data; end
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_key(input logic [7:0] old, input logic [1:0] kind);
    exp_key = old | 8'h04 | ((kind == 2'd1) ? 8'h02 : 8'h00);
  endfunction

  function automatic logic [2:0] exp_perm(input logic [7:0] old, input logic [1:0] kind, input logic [2:0] p);
    if (kind != 2'd1 && !old[1]) exp_perm = p & 3'b101;
    else exp_perm = p;
  endfunction

  task automatic load_key(input int idx, input logic [7:0] val);
    @(negedge clk);
    ld_en = 1; ld_idx = IDX_W'(idx); ld_data = val;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] kind,
                        input logic [2:0] p, input bit inject);
    logic [IDX_W-1:0] idx;
    logic [7:0] old;
    bit inr, got;
    int lat, rd0, wr0, dn0;
    idx = a[ADDR_W-1:12];
    inr = ({1'b0, a} < mem_size);
    old = kmem[idx];
    rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_kind = kind; req_perm = p;
    got = 0; lat = 0;
    while (!got && lat < 20) begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 0;
      if (inject && lat == 2) begin
        chk(busy == 1'b1, "R9 busy mid-access", 32'(busy), 1);
        req_valid = 1; req_addr = a ^ 20'h01000; req_kind = 2'd1;
      end
      if (lat == 3) req_valid = 0;
      if (done) got = 1;
    end
    if (inr) begin
      chk(got && lat == 4, "R8 latency", 32'(lat), 4);
      chk(perm_out == exp_perm(old, kind, p), (kind == 2'd1) ? "R7 perm store" : "R6 perm read",
          32'(perm_out), 32'(exp_perm(old, kind, p)));
      chk(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, "R8 one read one write",
          32'((rd_cnt - rd0) * 16 + (wr_cnt - wr0)), 32'h11);
      chk(last_rd_idx == idx && last_wr_idx == idx, "R2 key index",
          {last_rd_idx, last_wr_idx}, {idx, idx});
      chk(last_wr_data == exp_key(old, kind), "R3 R4 R5 key update",
          32'(last_wr_data), 32'(exp_key(old, kind)));
      chk(busy == 1'b0, "R9 busy low at done", 32'(busy), 0);
    end else begin
      chk(got && lat == 1, "R1 skip latency", 32'(lat), 1);
      chk(perm_out == p, "R1 perm pass", 32'(perm_out), 32'(p));
      chk(rd_cnt == rd0 && wr_cnt == wr0, "R1 no key access",
          32'((rd_cnt - rd0) + (wr_cnt - wr0)), 0);
    end
    @(negedge clk);
    chk(done == 1'b0 && done_cnt - dn0 == 1, "R9 single done",
        32'(done_cnt - dn0), 1);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4242);
    rst_n = 0; req_valid = 0; req_addr = '0; req_kind = '0; req_perm = '0;
    mem_size = 21'h0C0000; ld_en = 0; ld_idx = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !done && !key_rd_en && !key_wr_en, "R10 reset outputs",
        {busy, done, key_rd_en, key_wr_en}, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) load_key(i, 8'($urandom));

    // directed: changed flag clear vs set, all kinds
    load_key(5, 8'hF0);
    access(20'h05123, 2'd0, 3'b111, 0);   // R6 clear -> write removed
    load_key(6, 8'h82);
    access(20'h06000, 2'd2, 3'b111, 0);   // R6 dirty -> pass
    load_key(7, 8'h00);
    access(20'h07FFF, 2'd1, 3'b011, 0);   // R4 R7 store
    load_key(8, 8'h04);
    access(20'h08010, 2'd2, 3'b110, 0);   // R3 already referenced
    // boundary around memory size (R1)
    access(20'hBFFFF, 2'd0, 3'b111, 0);
    access(20'hC0000, 2'd1, 3'b010, 0);
    access(20'hFFFFF, 2'd2, 3'b101, 0);
    // request while busy ignored (R9)
    load_key(9, 8'h10);
    access(20'h09000, 2'd0, 3'b111, 1);

    for (int i = 0; i < 150; i++) begin
      access(20'($urandom), 2'($urandom % 3), 3'($urandom), (i % 7) == 0);
    end
    summary();
  end
endmodule